// File: doc/BRIEF.md
# Debug Register File Access Guard

This block holds the breakpoint-related debug state of a core. It has a bank of breakpoint address registers, a debug status register and a debug control register. Every register is reached through a single move-to / move-from command port. The command carries a 4-bit register index and a 64-bit data word. Before a command touches any state, the block classifies it and reports exactly one outcome. The outcome is either normal completion or one of three exception strobes: invalid-opcode, debug (general-detect trap) or general-protection.

The control register sanitizes itself. Its fixed-zero and fixed-one positions always read back at their required values, and its upper half always reads as zero. The general-detect enable in control bit 13 arms a trap on every access to indices 0–7. Handler entry clears that enable, so a handler can then inspect the registers. A task-switch pulse clears the per-task breakpoint enables at even control bits 0, 2, 4 and 6. The all-task enables at odd bits 1, 3, 5 and 7 are never cleared by hardware.

The command side has a valid/ready handshake, and `cmd_ready` is tied high, so the block never applies back-pressure. The response is a one-cycle pulse with no back-pressure, and the consumer must take it in the cycle it appears. Index map: 0–3 address registers, 4–5 reserved, 6 status, 7 control, 8–15 unimplemented.

Top module: `dbg_regfile_guard`

## Requirements
- R1: `cmd_ready` is always 1. Each accepted command (`cmd_valid`=1 at a rising edge) gives `rsp_valid`=1 for exactly the following cycle, and `rsp_valid` is 0 otherwise. At most one of `exc_ud`, `exc_db`, `exc_gp` is 1 at any time.
- R2: A command with index 8–15 raises `exc_ud`, changes no register and returns `rsp_rdata`=0.
- R3: While control bit 13 is 1, any command to indices 0–7 raises `exc_db`. It leaves the addressed register unchanged, returns 0 and sets status bit 13.
- R4: A `handler_entry` pulse clears control bit 13.
- R5: Control reads always show bits 15, 14, 12 and 11 as 0, bit 10 as 1, and bits 63–32 as 0, whatever was written.
- R6: With `mode64`=1, a control write with any of bits 63–32 set raises `exc_gp` and leaves the control register unchanged. With `mode64`=0, those bits are discarded and the write completes.
- R7: A `task_switch` pulse clears control bits 0, 2, 4 and 6 and leaves bits 1, 3, 5 and 7 unchanged. If a control write lands in the same cycle, the clear is applied after the write.
- R8: Outcome priority is invalid-opcode, then debug, then general-protection, then completion.
- R9: After reset the control register reads 0x400 and all other registers read 0.
- R10: Reads of indices 0–3 return the full 64-bit value last written.
- R11: Indices 4 and 5 read as 0, ignore writes and raise no exception.
- R12: A write to index 6 stores all 64 bits, and reads return the stored value. Write commands return `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode64 | input | 1 | Core is in 64-bit mode |
| handler_entry | input | 1 | Debug handler entry pulse |
| task_switch | input | 1 | Task switch pulse |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_write | input | 1 | 1 = move to register, 0 = move from register |
| cmd_index | input | 4 | Register index |
| cmd_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_rdata | output | 64 | Read data, 0 for writes and faults |
| exc_ud | output | 1 | Invalid-opcode strobe |
| exc_db | output | 1 | Debug (general-detect) strobe |
| exc_gp | output | 1 | General-protection strobe |

## Verification
A corrupted control register shows up at the first control read after it: a fixed bit out of place, or an enable that survived a clear. The next read of index 7 exposes it one cycle after the command. A stuck or missed general-detect enable shows on the very next access to indices 0–7, as a missing or spurious `exc_db`, and the status read after the handler pulse then confirms whether bit 13 was recorded. A mis-stored address or status word stays hidden until that index is read back, so every write in the stimulus is followed by a read of the same index.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [1:0] {
    OUT_OK = 2'd0,
    OUT_DB = 2'd1,
    OUT_GP = 2'd2,
    OUT_UD = 2'd3
  } outcome_e;

  localparam int CTRL_W      = 32;
  localparam int GD_BIT      = 13;
  localparam int BD_BIT      = 13;
  localparam logic [CTRL_W-1:0] CTRL_ZERO_MASK = 32'h0000_D800;
  localparam logic [CTRL_W-1:0] CTRL_ONE_MASK  = 32'h0000_0400;
  localparam logic [CTRL_W-1:0] CTRL_RESET     = 32'h0000_0400;
endpackage

// File: rtl/dbg_classify.sv
module dbg_classify
  import dbg_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 64,
  parameter int NUM_IMPL = 8
) (
  input  logic              write,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mode64,
  input  logic              gd_en,
  output outcome_e          outcome
);
  localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(7);
  localparam logic [IDX_W-1:0] IMPL_LIM = IDX_W'(NUM_IMPL);

  logic unimpl, upper_set;
  assign unimpl    = (idx >= IMPL_LIM);
  assign upper_set = |wdata[DATA_W-1:CTRL_W];

  always_comb begin
    if (unimpl)                                          outcome = OUT_UD;
    else if (gd_en)                                      outcome = OUT_DB;
    else if (write && idx == CTRL_IDX && mode64 && upper_set) outcome = OUT_GP;
    else                                                 outcome = OUT_OK;
  end
endmodule

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
  import dbg_pkg::*;
#(
  parameter int NUM_BP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              handler_entry,
  input  logic              task_switch,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic [CTRL_W-1:0] local_mask;
  logic [CTRL_W-1:0] ctrl_d;

  genvar gi;
  generate
    for (gi = 0; gi < CTRL_W; gi++) begin : g_lmask
      if (gi < 2*NUM_BP && (gi % 2) == 0) begin : g_on
        assign local_mask[gi] = 1'b1;
      end else begin : g_off
        assign local_mask[gi] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = (wdata & ~CTRL_ZERO_MASK) | CTRL_ONE_MASK;
    if (handler_entry) ctrl_d[GD_BIT] = 1'b0;
    if (task_switch) ctrl_d = ctrl_d & ~local_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= CTRL_RESET;
    else        ctrl_q <= ctrl_d;
  end

  // R4: handler entry leaves general-detect clear
  p_handler_clears_gd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    handler_entry |=> !ctrl_q[GD_BIT]);
  // R5: fixed positions hold their required values
  p_fixed_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[10] && (ctrl_q[15:14] == 2'b00) && (ctrl_q[12:11] == 2'b00));
  // R7: per-task enables are zero after a task switch, all-task ones kept
  p_task_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    task_switch |=> ((ctrl_q & local_mask) == '0));
  p_global_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (task_switch && !wr_en) |=> (ctrl_q[1] == $past(ctrl_q[1])) && (ctrl_q[7] == $past(ctrl_q[7])));
endmodule

// File: rtl/dbg_addr_bank.sv
module dbg_addr_bank #(
  parameter int NUM_BP = 4,
  parameter int DATA_W = 64,
  localparam int SEL_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] regs [NUM_BP];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BP; gi++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) regs[gi] <= '0;
        else if (wr_en && wr_sel == SEL_W'(gi)) regs[gi] <= wdata;
      end
    end
  endgenerate

  assign rd_data = regs[rd_sel];
endmodule

// File: rtl/dbg_regfile_guard.sv
module dbg_regfile_guard
  import dbg_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 64,
  parameter int NUM_BP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode64,
  input  logic              handler_entry,
  input  logic              task_switch,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              exc_ud,
  output logic              exc_db,
  output logic              exc_gp
);
  localparam int SEL_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1;
  localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(6);
  localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(7);
  localparam logic [IDX_W-1:0] BP_LIM   = IDX_W'(NUM_BP);
  localparam logic [IDX_W-1:0] IMPL_LIM = IDX_W'(8);

  outcome_e          outcome;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] bank_rd;
  logic [DATA_W-1:0] rd_val;
  logic              do_op, wr_ok, bank_wr, ctrl_wr;

  assign cmd_ready = 1'b1;

  dbg_classify #(.IDX_W(IDX_W), .DATA_W(DATA_W), .NUM_IMPL(8)) u_cls (
    .write  (cmd_write),
    .idx    (cmd_index),
    .wdata  (cmd_wdata),
    .mode64 (mode64),
    .gd_en  (ctrl_q[GD_BIT]),
    .outcome(outcome)
  );

  assign do_op   = cmd_valid && (outcome == OUT_OK);
  assign wr_ok   = do_op && cmd_write;
  assign bank_wr = wr_ok && (cmd_index < BP_LIM);
  assign ctrl_wr = wr_ok && (cmd_index == CTRL_IDX);

  dbg_addr_bank #(.NUM_BP(NUM_BP), .DATA_W(DATA_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bank_wr),
    .wr_sel (cmd_index[SEL_W-1:0]),
    .wdata  (cmd_wdata),
    .rd_sel (cmd_index[SEL_W-1:0]),
    .rd_data(bank_rd)
  );

  dbg_ctrl_reg #(.NUM_BP(NUM_BP)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (ctrl_wr),
    .wdata        (cmd_wdata[CTRL_W-1:0]),
    .handler_entry(handler_entry),
    .task_switch  (task_switch),
    .ctrl_q       (ctrl_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else if (wr_ok && cmd_index == STAT_IDX) status_q <= cmd_wdata;
    else if (cmd_valid && outcome == OUT_DB) status_q[BD_BIT] <= 1'b1;
  end

  always_comb begin
    if (cmd_index < BP_LIM)          rd_val = bank_rd;
    else if (cmd_index == STAT_IDX)  rd_val = status_q;
    else if (cmd_index == CTRL_IDX)  rd_val = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
    else                             rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      exc_ud    <= 1'b0;
      exc_db    <= 1'b0;
      exc_gp    <= 1'b0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_rdata <= (do_op && !cmd_write) ? rd_val : '0;
      exc_ud    <= cmd_valid && (outcome == OUT_UD);
      exc_db    <= cmd_valid && (outcome == OUT_DB);
      exc_gp    <= cmd_valid && (outcome == OUT_GP);
    end
  end

  // R1: response one cycle after acceptance, single outcome
  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);
  p_one_outcome_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({exc_ud, exc_db, exc_gp}) <= 1);
  p_no_exc_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(exc_ud || exc_db || exc_gp));
  // R2: unimplemented index faults with zero data
  p_ud_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_index >= IMPL_LIM) |=> (exc_ud && rsp_rdata == '0));
  // R3: general-detect trap records the access
  p_gd_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_index < IMPL_LIM && ctrl_q[GD_BIT]) |=> (exc_db && status_q[BD_BIT]));
  // R6: faulting control write leaves control untouched
  p_gp_keeps_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && cmd_index == CTRL_IDX && mode64 && |cmd_wdata[DATA_W-1:CTRL_W]
     && !ctrl_q[GD_BIT] && !task_switch && !handler_entry) |=> (exc_gp && ctrl_q == $past(ctrl_q)));
  // R11: reserved indices read zero without fault
  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write && !ctrl_q[GD_BIT] && (cmd_index == IDX_W'(4) || cmd_index == IDX_W'(5)))
    |=> (rsp_rdata == '0 && !exc_ud && !exc_db && !exc_gp));
endmodule

// File: tb/sim_dbg_regfile_guard.sv
module sim_dbg_regfile_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode64 = 1'b0, handler_entry = 1'b0, task_switch = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [3:0]  cmd_index = '0;
  logic [63:0] cmd_wdata = '0;
  logic        cmd_ready, rsp_valid, exc_ud, exc_db, exc_gp;
  logic [63:0] rsp_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #5ns clk = ~clk;

  dbg_regfile_guard u0 (
    .clk(clk), .rst_n(rst_n), .mode64(mode64), .handler_entry(handler_entry),
    .task_switch(task_switch), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_index(cmd_index), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .exc_ud(exc_ud),
    .exc_db(exc_db), .exc_gp(exc_gp)
  );

  // expected outcome code: 0 complete, 1 debug, 2 general-protection, 3 invalid-opcode
  typedef struct packed {
    logic        wr;
    logic        m64;
    logic [3:0]  idx;
    logic [63:0] wd;
    logic [1:0]  exp;
    logic [63:0] rd;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VT [NV] = '{
    '{1'b0, 1'b0, 4'd7, 64'h0, 2'd0, 64'h400},                      // R9 control reset
    '{1'b0, 1'b0, 4'd0, 64'h0, 2'd0, 64'h0},                        // R9 address reset
    '{1'b0, 1'b0, 4'd6, 64'h0, 2'd0, 64'h0},                        // R9 status reset
    '{1'b1, 1'b0, 4'd0, 64'hDEADBEEF_12345678, 2'd0, 64'h0},        // R12 write returns 0
    '{1'b0, 1'b0, 4'd0, 64'h0, 2'd0, 64'hDEADBEEF_12345678},        // R10
    '{1'b1, 1'b0, 4'd3, 64'hFFFF0000_00000001, 2'd0, 64'h0},
    '{1'b0, 1'b0, 4'd3, 64'h0, 2'd0, 64'hFFFF0000_00000001},        // R10
    '{1'b1, 1'b0, 4'd7, 64'hABCD0000_FFFFDFFF, 2'd0, 64'h0},        // R6 legacy mode discards upper
    '{1'b0, 1'b0, 4'd7, 64'h0, 2'd0, 64'h00000000_FFFF07FF},        // R5
    '{1'b1, 1'b1, 4'd7, 64'h00000001_00000000, 2'd2, 64'h0},        // R6 fault
    '{1'b0, 1'b0, 4'd7, 64'h0, 2'd0, 64'h00000000_FFFF07FF},        // R6 unchanged
    '{1'b1, 1'b1, 4'd7, 64'h0, 2'd0, 64'h0},
    '{1'b0, 1'b0, 4'd7, 64'h0, 2'd0, 64'h400},                      // R5 bit 10 forced
    '{1'b1, 1'b0, 4'd5, 64'h1234, 2'd0, 64'h0},                     // R11
    '{1'b0, 1'b0, 4'd5, 64'h0, 2'd0, 64'h0},                        // R11
    '{1'b0, 1'b0, 4'd4, 64'h0, 2'd0, 64'h0},                        // R11
    '{1'b1, 1'b0, 4'd6, 64'hA5, 2'd0, 64'h0},
    '{1'b0, 1'b0, 4'd6, 64'h0, 2'd0, 64'hA5},                       // R12
    '{1'b0, 1'b0, 4'd9, 64'h0, 2'd3, 64'h0},                        // R2 read
    '{1'b1, 1'b0, 4'd15, 64'h55, 2'd3, 64'h0},                      // R2 write
    '{1'b1, 1'b0, 4'd7, 64'h2000, 2'd0, 64'h0},                     // arm general detect
    '{1'b0, 1'b0, 4'd7, 64'h0, 2'd1, 64'h0},                        // R3 read trapped
    '{1'b1, 1'b0, 4'd0, 64'h0, 2'd1, 64'h0}                         // R3 write trapped
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic wr, input logic m64, input logic [3:0] idx,
                        input logic [63:0] wd, input logic [1:0] exp,
                        input logic [63:0] erd, input string req);
    logic [3:0] exp_strobes;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; mode64 = m64; cmd_index = idx; cmd_wdata = wd;
    check({req, " ready"}, {63'h0, cmd_ready}, 64'h1);
    @(negedge clk);
    cmd_valid = 1'b0; mode64 = 1'b0;
    exp_strobes = {1'b1, exp == 2'd3, exp == 2'd1, exp == 2'd2};
    check({req, " valid/ud/db/gp"}, {60'h0, rsp_valid, exc_ud, exc_db, exc_gp}, {60'h0, exp_strobes});
    check({req, " rdata"}, rsp_rdata, erd);
  endtask

  task automatic pulse(input bit which);
    @(negedge clk);
    if (which) handler_entry = 1'b1; else task_switch = 1'b1;
    @(negedge clk);
    handler_entry = 1'b0; task_switch = 1'b0;
  endtask

  initial begin
    #2ms;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: nothing reported out of reset
    check("R1 idle after reset", {60'h0, rsp_valid, exc_ud, exc_db, exc_gp}, 64'h0);

    for (int i = 0; i < NV; i++)
      do_cmd(VT[i].wr, VT[i].m64, VT[i].idx, VT[i].wd, VT[i].exp, VT[i].rd, $sformatf("vec%0d", i));

    // R8: invalid-opcode wins over the general-detect trap
    do_cmd(1'b0, 1'b0, 4'd12, 64'h0, 2'd3, 64'h0, "R8 ud over db");
    // R8: debug wins over general-protection
    do_cmd(1'b1, 1'b1, 4'd7, 64'hF_00000000, 2'd1, 64'h0, "R8 db over gp");
    // R1: response lasts one cycle only
    @(negedge clk);
    check("R1 single pulse", {63'h0, rsp_valid}, 64'h0);

    // R4: handler entry reopens access
    pulse(1'b1);
    do_cmd(1'b0, 1'b0, 4'd7, 64'h0, 2'd0, 64'h400, "R4 gd cleared");
    do_cmd(1'b0, 1'b0, 4'd6, 64'h0, 2'd0, 64'h20A5, "R3 status bit 13");
    do_cmd(1'b0, 1'b0, 4'd0, 64'h0, 2'd0, 64'hDEADBEEF_12345678, "R3 trapped write left reg");

    // R7: task switch clears even enables only
    do_cmd(1'b1, 1'b0, 4'd7, 64'hFF, 2'd0, 64'h0, "R7 set enables");
    pulse(1'b0);
    do_cmd(1'b0, 1'b0, 4'd7, 64'h0, 2'd0, 64'h4AA, "R7 after switch");
    // R7: clear applied after a same-cycle write
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_index = 4'd7; cmd_wdata = 64'h55; task_switch = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; task_switch = 1'b0;
    check("R7 combined valid", {63'h0, rsp_valid}, 64'h1);
    do_cmd(1'b0, 1'b0, 4'd7, 64'h0, 2'd0, 64'h400, "R7 write then clear");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule